// File: doc/BRIEF.md
# Configurable Systolic Pixel Filter Grid

This block is a rectangular grid of small processing elements that filters a grayscale image streamed in at one pixel per clock. Each element receives a vertical operand from above and a horizontal operand from its left. It applies one of a small set of pixel operations and registers the result. That registered result feeds both the element below it and the element to its right. The operands for the top row and the left column come from a 3x3 neighbourhood of the current pixel, which arrives as nine taps, and a configuration entry picks the tap for each border input. The filtered output is taken from the right-hand edge, at a row chosen by configuration.

All behaviour comes from a small configuration store that is written one 4-bit entry at a time through a write-enable, address and data port. The store holds an operation code for every element, a tap selector for every border input and an output row selector. It is written while no valid pixels are in flight. Internal skew registers line up all operands so that every element works on taps of the same pixel. The output therefore always belongs to a single input pixel, after a fixed latency of rows+cols-1 cycles, and a valid flag travels with it.

The row and column counts are parameters, from 1x1 up to 7x7. Operation codes with no defined function act as a pass-through of the horizontal operand. A configuration that has been evolved for fewer columns therefore keeps its function when the grid is widened with pass-through elements.

Top module: `pixel_grid`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0 and out_pixel is 0. Reset clears every configuration entry to 0.
- R2: out_valid equals px_valid delayed by exactly ROWS+COLS-1 clock cycles, and it is never 1 within the first ROWS+COLS-1 cycles after reset.
- R3: Element operation codes, with n the vertical operand and w the horizontal operand, all unsigned 8-bit: 0 gives w; 1 gives n+w clamped to 255; 2 gives n-w clamped to 0; 3 gives n>>1; 4 gives max(n,w); 5 gives min(n,w); 6 gives (n+w)>>1 computed without overflow; 7 gives n.
- R4: Operation codes 8 to 15 behave exactly like code 0 and pass w on unchanged.
- R5: Each top-row and left-column input takes window tap k when its selector holds k, for k from 0 to 8. Tap k is win_taps[8k+7:8k], and tap 4 is the centre. A selector value of 9 to 15 takes tap 0.
- R6: The element in row r (r>0) takes its vertical operand from the element at (r-1, c). The element in column c (c>0) takes its horizontal operand from the element at (r, c-1). Every element result in the grid belongs to the same input pixel.
- R7: out_pixel is the result of the right-most element of row orow. An orow value of ROWS or more selects row 0.
- R8: Configuration address map (one 4-bit entry each): addresses 0 to ROWS*COLS-1 hold operation codes in row-major order (address r*COLS+c). The next COLS addresses hold the top-row selectors for columns 0 upward. The next ROWS addresses hold the left-column selectors for rows 0 upward. The next address holds orow. Writes to any higher address leave all behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW | Configuration entry address |
| cfg_data | input | 4 | Configuration entry value |
| px_valid | input | 1 | Window taps hold a valid pixel this cycle |
| win_taps | input | 72 | Nine 8-bit neighbourhood taps, tap k at bits 8k+7:8k |
| out_valid | output | 1 | out_pixel holds a filtered pixel |
| out_pixel | output | 8 | Filtered pixel |

## Verification
The first stream uses the reset configuration and a ragged valid pattern, which separates a wrong latency or a lost valid from a datapath error. Each defined operation is then applied uniformly across the grid, using random taps and also all-zero, all-255, alternating and high-value taps. These patterns show whether saturation, averaging without overflow and operand order are right. Further streams use random per-element operations with different selectors and output rows, which show whether any skew register is missing because such a register mixes taps of neighbouring pixels. The last streams use undefined opcodes, out-of-range selectors and rows, and writes above the address map, and they confirm at the output that these fall back as specified or are ignored.

// File: rtl/pixel_grid_pkg.sv
`timescale 1ns/1ps
package pixel_grid_pkg;
  localparam int PIX_W  = 8;
  localparam int N_TAPS = 9;
  localparam int OP_W   = 4;

  typedef logic [PIX_W-1:0] pix_t;

  localparam logic [OP_W-1:0] OP_PASS_W = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD    = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB    = 4'd2;
  localparam logic [OP_W-1:0] OP_SHR    = 4'd3;
  localparam logic [OP_W-1:0] OP_MAX    = 4'd4;
  localparam logic [OP_W-1:0] OP_MIN    = 4'd5;
  localparam logic [OP_W-1:0] OP_AVG    = 4'd6;
  localparam logic [OP_W-1:0] OP_PASS_N = 4'd7;

  // One element operation on an (n, w) operand pair.
  function automatic pix_t pe_eval(input logic [OP_W-1:0] op, input pix_t n, input pix_t w);
    logic [PIX_W:0] sum;
    pix_t r;
    sum = {1'b0, n} + {1'b0, w};
    case (op)
      OP_ADD:    r = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
      OP_SUB:    r = (n >= w) ? pix_t'(n - w) : '0;
      OP_SHR:    r = n >> 1;
      OP_MAX:    r = (n > w) ? n : w;
      OP_MIN:    r = (n < w) ? n : w;
      OP_AVG:    r = sum[PIX_W:1];
      OP_PASS_N: r = n;
      default:   r = w;
    endcase
    return r;
  endfunction

  // Pick one neighbourhood tap; out-of-range selectors fall back to tap 0.
  function automatic pix_t tap_pick(input logic [N_TAPS*PIX_W-1:0] taps, input logic [OP_W-1:0] sel);
    pix_t p;
    p = taps[PIX_W-1:0];
    for (int k = 1; k < N_TAPS; k++)
      if (int'(sel) == k) p = taps[k*PIX_W +: PIX_W];
    return p;
  endfunction
endpackage

// File: rtl/pg_delay.sv
`timescale 1ns/1ps
module pg_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[DEPTH-1];
endmodule

// File: rtl/pg_pe.sv
`timescale 1ns/1ps
module pg_pe
  import pixel_grid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  pix_t            n_i,
  input  pix_t            w_i,
  output pix_t            res_o
);
  pix_t res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= pe_eval(op_i, n_i, w_i);
  end

  assign res_o = res_q;

  AST_ADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |=> (res_q >= $past(n_i) && res_q >= $past(w_i))); // R3
  AST_SUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB) |=> (res_q <= $past(n_i))); // R3
  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MAX) |=> (res_q >= $past(n_i) && res_q >= $past(w_i))); // R3
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MIN) |=> (res_q <= $past(n_i) && res_q <= $past(w_i))); // R3
  AST_SPARE_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd8) |=> (res_q == $past(w_i))); // R4
endmodule

// File: rtl/pg_cfg.sv
`timescale 1ns/1ps
module pg_cfg
  import pixel_grid_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int AW   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [AW-1:0]                   addr_i,
  input  logic [OP_W-1:0]                 data_i,
  output logic [ROWS*COLS-1:0][OP_W-1:0]  ops_o,
  output logic [COLS-1:0][OP_W-1:0]       top_o,
  output logic [ROWS-1:0][OP_W-1:0]       left_o,
  output logic [OP_W-1:0]                 orow_o
);
  localparam int NPE    = ROWS * COLS;
  localparam int BASE_T = NPE;
  localparam int BASE_L = NPE + COLS;
  localparam int ADDR_O = NPE + COLS + ROWS;
  localparam int NENT   = ADDR_O + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops_o  <= '0;
      top_o  <= '0;
      left_o <= '0;
      orow_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NPE; i++)
        if (int'(addr_i) == i) ops_o[i] <= data_i;
      for (int i = 0; i < COLS; i++)
        if (int'(addr_i) == BASE_T + i) top_o[i] <= data_i;
      for (int i = 0; i < ROWS; i++)
        if (int'(addr_i) == BASE_L + i) left_o[i] <= data_i;
      if (int'(addr_i) == ADDR_O) orow_o <= data_i;
    end
  end

  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(addr_i) >= NENT) |=>
      ($stable(ops_o) && $stable(top_o) && $stable(left_o) && $stable(orow_o))); // R8
  AST_ROW_ENTRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(addr_i) == ADDR_O) |=> (orow_o == $past(data_i))); // R8
endmodule

// File: rtl/pixel_grid.sv
`timescale 1ns/1ps
module pixel_grid
  import pixel_grid_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int COLS   = 3,
  parameter int CFG_AW = $clog2(ROWS*COLS + ROWS + COLS + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [3:0]               cfg_data,
  input  logic                     px_valid,
  input  logic [N_TAPS*PIX_W-1:0]  win_taps,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pixel
);
  localparam int LAT = ROWS + COLS - 1;

  logic [ROWS*COLS-1:0][OP_W-1:0] ops;
  logic [COLS-1:0][OP_W-1:0]      top_sel;
  logic [ROWS-1:0][OP_W-1:0]      left_sel;
  logic [OP_W-1:0]                orow;

  pg_cfg #(.ROWS(ROWS), .COLS(COLS), .AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr), .data_i(cfg_data),
    .ops_o(ops), .top_o(top_sel), .left_o(left_sel), .orow_o(orow)
  );

  pix_t top_in  [COLS];
  pix_t left_in [ROWS];
  pix_t res     [ROWS][COLS];
  pix_t row_out [ROWS];

  // Border inputs: tap choice, then skew so column c / row r sees the same pixel.
  for (genvar c = 0; c < COLS; c++) begin : g_top
    pix_t pick;
    assign pick = tap_pick(win_taps, top_sel[c]);
    if (c == 0) begin : g_direct
      assign top_in[c] = pick;
    end else begin : g_skew
      pg_delay #(.W(PIX_W), .DEPTH(c)) u_skew (
        .clk(clk), .rst_n(rst_n), .d_i(pick), .q_o(top_in[c]));
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_left
    pix_t pick;
    assign pick = tap_pick(win_taps, left_sel[r]);
    if (r == 0) begin : g_direct
      assign left_in[r] = pick;
    end else begin : g_skew
      pg_delay #(.W(PIX_W), .DEPTH(r)) u_skew (
        .clk(clk), .rst_n(rst_n), .d_i(pick), .q_o(left_in[r]));
    end
  end

  // Element grid: one registered result per element feeds south and east.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      pix_t n_op, w_op;
      if (r == 0) begin : g_n_border
        assign n_op = top_in[c];
      end else begin : g_n_inner
        assign n_op = res[r-1][c];
      end
      if (c == 0) begin : g_w_border
        assign w_op = left_in[r];
      end else begin : g_w_inner
        assign w_op = res[r][c-1];
      end
      pg_pe u_pe (
        .clk(clk), .rst_n(rst_n), .op_i(ops[r*COLS + c]),
        .n_i(n_op), .w_i(w_op), .res_o(res[r][c]));
    end
  end

  // East edge: pad upper rows so every row reaches the output after LAT cycles.
  for (genvar r = 0; r < ROWS; r++) begin : g_east
    if (r == ROWS - 1) begin : g_direct
      assign row_out[r] = res[r][COLS-1];
    end else begin : g_pad
      pg_delay #(.W(PIX_W), .DEPTH(ROWS - 1 - r)) u_pad (
        .clk(clk), .rst_n(rst_n), .d_i(res[r][COLS-1]), .q_o(row_out[r]));
    end
  end

  always_comb begin
    out_pixel = row_out[0];
    for (int k = 1; k < ROWS; k++)
      if (int'(orow) == k) out_pixel = row_out[k];
  end

  logic [0:0] vld_q;
  pg_delay #(.W(1), .DEPTH(LAT)) u_vld (
    .clk(clk), .rst_n(rst_n), .d_i(px_valid), .q_o(vld_q));
  assign out_valid = vld_q[0];

  // Cycles since reset, saturating; watched by the startup assertion.
  logic [7:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_rst) < LAT) |-> !out_valid); // R2
  AST_IDLE_OUT_ZERO: assert property (@(posedge clk)
    (!rst_n) |=> (!out_valid && out_pixel == '0)); // R1
endmodule

// File: tb/pixel_grid_tb.sv
`timescale 1ns/1ps
module pixel_grid_tb;
  localparam int ROWS = 3;
  localparam int COLS = 3;
  localparam int AW   = 5;
  localparam int LAT  = ROWS + COLS - 1;
  localparam int NPE  = ROWS * COLS;
  localparam int NENT = NPE + COLS + ROWS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0]    cfg_data = '0;
  logic          px_valid = 1'b0;
  logic [71:0]   win_taps = '0;
  logic          out_valid;
  logic [7:0]    out_pixel;

  always #2 clk = ~clk;

  pixel_grid #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .px_valid(px_valid), .win_taps(win_taps), .out_valid(out_valid), .out_pixel(out_pixel));

  int n_checks = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // Mirror of the configuration as the requirements define it.
  int m_op [ROWS][COLS];
  int m_top [COLS];
  int m_left [ROWS];
  int m_orow = 0;
  // Wanted configuration, written by apply_cfg.
  int w_op [ROWS][COLS];
  int w_top [COLS];
  int w_left [ROWS];
  int w_orow = 0;

  typedef struct { bit v; int px; } exp_t;
  exp_t q [$];

  function automatic int ref_op(int op, int a, int b);
    int t;
    if (op == 1) begin t = a + b; return (t > 255) ? 255 : t; end
    if (op == 2) begin t = a - b; return (t < 0) ? 0 : t; end
    if (op == 3) return a / 2;
    if (op == 4) return (a >= b) ? a : b;
    if (op == 5) return (a <= b) ? a : b;
    if (op == 6) return (a + b) / 2;
    if (op == 7) return a;
    return b;
  endfunction

  function automatic int ref_tap(logic [71:0] t, int s);
    int k;
    k = (s > 8) ? 0 : s;
    return int'(t[k*8 +: 8]);
  endfunction

  function automatic int ref_out(logic [71:0] t);
    int g [ROWS][COLS];
    int a, b, row;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        a = (r == 0) ? ref_tap(t, m_top[c]) : g[r-1][c];
        b = (c == 0) ? ref_tap(t, m_left[r]) : g[r][c-1];
        g[r][c] = ref_op(m_op[r][c], a, b);
      end
    row = (m_orow >= ROWS) ? 0 : m_orow;
    return g[row][COLS-1];
  endfunction

  function automatic logic [71:0] mk_taps(int mode);
    logic [71:0] t;
    for (int k = 0; k < 9; k++) begin
      case (mode)
        1: t[k*8 +: 8] = 8'hFF;
        2: t[k*8 +: 8] = 8'h00;
        3: t[k*8 +: 8] = (k % 2 == 0) ? 8'hFF : 8'h00;
        4: t[k*8 +: 8] = 8'(200 + ($urandom % 56));
        default: t[k*8 +: 8] = 8'($urandom);
      endcase
    end
    return t;
  endfunction

  task automatic check(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // One clock: compare outputs, then drive the next inputs.
  task automatic step(bit v, logic [71:0] t, bit we, int addr, int data);
    exp_t e;
    @(negedge clk);
    if (q.size() == LAT) begin
      e = q.pop_front();
      check({cur_req, "/R2 valid"}, int'(out_valid), int'(e.v));
      if (e.v) check({cur_req, " pixel"}, int'(out_pixel), e.px);
    end else begin
      check("R2 startup valid", int'(out_valid), 0);
    end
    px_valid = v;
    win_taps = t;
    cfg_we   = we;
    cfg_addr = AW'(addr);
    cfg_data = 4'(data);
    e.v  = v;
    e.px = ref_out(t);
    q.push_back(e);
    if (we && addr < NENT) begin
      if (addr < NPE) m_op[addr / COLS][addr % COLS] = data;
      else if (addr < NPE + COLS) m_top[addr - NPE] = data;
      else if (addr < NPE + COLS + ROWS) m_left[addr - NPE - COLS] = data;
      else m_orow = data;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, mk_taps(0), 0, 0, 0);
  endtask

  task automatic apply_cfg();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) step(0, mk_taps(0), 1, r*COLS + c, w_op[r][c]);
    for (int c = 0; c < COLS; c++) step(0, mk_taps(0), 1, NPE + c, w_top[c]);
    for (int r = 0; r < ROWS; r++) step(0, mk_taps(0), 1, NPE + COLS + r, w_left[r]);
    step(0, mk_taps(0), 1, NPE + COLS + ROWS, w_orow);
    idle(1);
  endtask

  task automatic stream(int n, bit ragged);
    for (int i = 0; i < n; i++)
      step(ragged ? bit'($urandom % 2) : 1'b1, mk_taps(i % 5), 0, 0, 0);
    idle(LAT + 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      m_left[r] = 0;
      for (int c = 0; c < COLS; c++) m_op[r][c] = 0;
    end
    for (int c = 0; c < COLS; c++) m_top[c] = 0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 pixel in reset", int'(out_pixel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 pixel after reset", int'(out_pixel), 0);

    // R2: reset configuration (all pass-w, tap 0, row 0), ragged valid.
    cur_req = "R2";
    stream(60, 1);

    // R3: each defined operation across the whole grid.
    cur_req = "R3";
    for (int op = 0; op < 8; op++) begin
      for (int r = 0; r < ROWS; r++) begin
        w_left[r] = 8 - r;
        for (int c = 0; c < COLS; c++) w_op[r][c] = op;
      end
      for (int c = 0; c < COLS; c++) w_top[c] = c + 1;
      w_orow = op % ROWS;
      apply_cfg();
      stream(30, 0);
    end

    // R4: spare opcodes behave as pass-w.
    cur_req = "R4";
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_op[r][c] = 8 + ((r*COLS + c) % 8);
    w_orow = 1;
    apply_cfg();
    stream(30, 0);

    // R5: selectors 9..15 fall back to tap 0, plus in-range taps.
    cur_req = "R5";
    for (int r = 0; r < ROWS; r++) begin
      w_left[r] = 9 + 2*r;
      for (int c = 0; c < COLS; c++) w_op[r][c] = 1 + ((r + c) % 7);
    end
    w_top[0] = 15; w_top[1] = 4; w_top[2] = 10;
    w_orow = 2;
    apply_cfg();
    stream(30, 0);

    // R6: random mixed configurations, each output row.
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      for (int r = 0; r < ROWS; r++) begin
        w_left[r] = $urandom % 9;
        for (int c = 0; c < COLS; c++) w_op[r][c] = $urandom % 8;
      end
      for (int c = 0; c < COLS; c++) w_top[c] = $urandom % 9;
      w_orow = k % ROWS;
      apply_cfg();
      stream(25, 0);
    end

    // R7: out-of-range output row selects row 0.
    cur_req = "R7";
    w_orow = 6;
    apply_cfg();
    stream(25, 0);
    w_orow = 15;
    apply_cfg();
    stream(25, 0);

    // R8: writes above the map change nothing.
    cur_req = "R8";
    for (int a = NENT; a < (1 << AW); a++) step(0, mk_taps(0), 1, a, a % 16);
    idle(1);
    stream(30, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule